// File: doc/BRIEF.md
# Bistable Persistence Column Engine

The engine keeps a display raster in an external column memory, two bits per pixel. Each pixel has three meaningful states: dark, lit, and freshly lit. When an acquired sample arrives as a column index plus a vertical position, the engine does a read-modify-write of the memory word that holds that pixel and marks it freshly lit. A refresh strobe starts a sweep over the whole raster. The sweep visits every column in ascending order and every word of a column in ascending order. It turns freshly lit pixels into lit pixels, and it extinguishes lit pixels at random with a probability set by an 8-bit register. This gives variable persistence.

Samples enter on a valid/ready stream. A sample is taken in a cycle where `smp_valid` and `smp_ready` are both high. While stalled, the producer must hold `smp_valid` and the payload steady. Ready drops for one cycle during each write-back. During a sweep, ready also stays low for any sample whose column the sweep has not yet finished. Samples to columns that are already swept go ahead of the sweep, and the sweep waits for them. The refresh strobe, the probability register and the busy flag are plain signals.

The memory port carries one access per cycle. A read returns its data on `mem_rdata` in the cycle after `mem_rd_en`. A write commits at the clock edge on which `mem_wr_en` is high.

Top module: `persist_column_engine`

## Requirements
- R1: After reset, `sweep_busy`, `mem_rd_en` and `mem_wr_en` are low and `smp_ready` is high.
- R2: A sample for column c and row r touches word address c*32 + r[8:4], which is `{c, r[8:4]}`, and lane r[3:0], which is bits [2*lane+1:2*lane] of that word. The read is issued in the cycle the sample is accepted and the write in the next cycle. The written word sets that lane to 11 and leaves the other 15 lanes unchanged.
- R3: A sweep rewrites every pixel holding 11 (freshly lit) as 01 (lit).
- R4: A sweep leaves 00 (dark) as 00, and it turns the unused code 10 into 00.
- R5: With a decay probability of 0, every 01 pixel stays 01 through a sweep.
- R6: During a sweep, a 01 pixel becomes 00 when its pseudo-random byte is below the probability register, and otherwise it stays 01. Over 4096 lit pixels, a register of 128 extinguishes between 25% and 75% of them and a register of 255 extinguishes at least 90%.
- R7: A refresh strobe while idle raises `sweep_busy` on the next edge. The sweep then writes the words in address order 0 to NUM_COLS*32-1, one read-then-write pair every two cycles. With no samples arriving, `sweep_busy` stays high for exactly NUM_COLS*64 cycles and falls right after the last write.
- R8: A refresh strobe while a sweep is running has no effect: the busy time stays the same and no word is visited twice.
- R9: During a sweep, a sample for a column below the one being swept is accepted within two cycles. A sample for the current or a later column is held until the sweep has moved past that column. Every sample accepted during a sweep ends the sweep as 11.
- R10: The memory port never reads and writes in the same cycle. Every read is followed at once by a write to the same address, so no two read-modify-writes interleave.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_valid | input | 1 | Sample stream valid |
| smp_ready | output | 1 | Sample stream ready |
| smp_col | input | 3 | Sample column index |
| smp_row | input | 9 | Sample vertical position |
| refresh_start | input | 1 | One-cycle strobe that starts a sweep |
| decay_prob | input | 8 | Extinction probability, in units of 1/256 |
| sweep_busy | output | 1 | High while a sweep is in progress |
| mem_rd_en | output | 1 | Column memory read request |
| mem_wr_en | output | 1 | Column memory write request |
| mem_addr | output | 8 | Word address, {column, word} |
| mem_wdata | output | 32 | Write data, 16 pixels |
| mem_rdata | input | 32 | Read data, valid the cycle after a read |

## Verification
A corrupted pixel code shows in the word written back within two cycles of the read. A wrong transform therefore leaves a wrong value in the memory model as soon as one sweep or one sample completes, and a full-raster comparison catches it. A wrong sweep counter shows as an out-of-order write address on the very next write-back, or as a busy time that differs from NUM_COLS*64 cycles. A bad stall decision shows as a sample accepted too early during a sweep, which leaves a pixel at 01 instead of 11 once that sweep ends.

// File: rtl/persist_pkg.sv
package persist_pkg;

  typedef enum logic [1:0] {
    PX_DARK  = 2'b00,
    PX_LIT   = 2'b01,
    PX_SPARE = 2'b10,
    PX_FRESH = 2'b11
  } pix_code_t;

  typedef enum logic [1:0] {
    ST_ISSUE,
    ST_SMP_WB,
    ST_SWP_WB
  } eng_state_t;

  localparam logic [15:0] LFSR_TAPS = 16'hB400;

  // Advance a 16-bit Galois LFSR by 'steps' shifts (at most 16).
  function automatic logic [15:0] lfsr16_run(input logic [15:0] seed, input int steps);
    logic [15:0] v;
    v = seed;
    for (int k = 0; k < 16; k++) begin
      if (k < steps) v = v[0] ? ((v >> 1) ^ LFSR_TAPS) : (v >> 1);
    end
    return v;
  endfunction

endpackage

// File: rtl/persist_rand.sv
module persist_rand #(
  parameter int LANES = 16,
  parameter int RND_W = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   advance,
  output logic [LANES*RND_W-1:0] rnd
);
  import persist_pkg::*;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    localparam logic [15:0] SEED = {4'(g), 12'h5A3};
    logic [15:0] st_q;

    always_ff @(posedge clk) begin
      if (!rst_n)       st_q <= SEED;
      else if (advance) st_q <= lfsr16_run(st_q, RND_W);
    end

    assign rnd[g*RND_W +: RND_W] = st_q[RND_W-1:0];
  end

endmodule

// File: rtl/persist_xform.sv
module persist_xform #(
  parameter int LANES  = 16,
  parameter int RND_W  = 8,
  parameter int LANE_W = 4
) (
  input  logic [2*LANES-1:0]     rd_word,
  input  logic                   sweep_mode,
  input  logic [LANE_W-1:0]      tgt_lane,
  input  logic [LANES*RND_W-1:0] rnd,
  input  logic [RND_W-1:0]       prob,
  output logic [2*LANES-1:0]     wr_word
);
  import persist_pkg::*;

  for (genvar g = 0; g < LANES; g++) begin : g_pix
    pix_code_t cur;
    pix_code_t nxt;
    logic      fade;

    assign cur  = pix_code_t'(rd_word[2*g +: 2]);
    assign fade = rnd[g*RND_W +: RND_W] < prob;

    always_comb begin
      nxt = cur;
      if (sweep_mode) begin
        unique case (cur)
          PX_FRESH: nxt = PX_LIT;
          PX_LIT:   nxt = fade ? PX_DARK : PX_LIT;
          default:  nxt = PX_DARK;
        endcase
      end else if (tgt_lane == LANE_W'(g)) begin
        nxt = PX_FRESH;
      end
    end

    assign wr_word[2*g +: 2] = nxt;
  end

endmodule

// File: rtl/persist_sweep_seq.sv
module persist_sweep_seq #(
  parameter int NUM_COLS = 8,
  parameter int WPC      = 32,
  parameter int COL_W    = 3,
  parameter int WSEL_W   = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              step,
  output logic              active,
  output logic [COL_W-1:0]  col,
  output logic [WSEL_W-1:0] word
);
  logic last_word;
  logic last_col;

  assign last_word = word == WSEL_W'(WPC - 1);
  assign last_col  = col == COL_W'(NUM_COLS - 1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active <= 1'b0;
      col    <= '0;
      word   <= '0;
    end else if (!active) begin
      if (start) begin
        active <= 1'b1;
        col    <= '0;
        word   <= '0;
      end
    end else if (step) begin
      if (last_word) begin
        word <= '0;
        if (last_col) active <= 1'b0;
        else          col    <= col + 1'b1;
      end else begin
        word <= word + 1'b1;
      end
    end
  end

endmodule

// File: rtl/persist_column_engine.sv
module persist_column_engine #(
  parameter int NUM_COLS   = 8,
  parameter int COL_PIXELS = 512,
  parameter int WORD_BITS  = 32,
  parameter int RND_W      = 8,
  localparam int PPW    = WORD_BITS / 2,
  localparam int WPC    = COL_PIXELS / PPW,
  localparam int COL_W  = $clog2(NUM_COLS),
  localparam int ROW_W  = $clog2(COL_PIXELS),
  localparam int LANE_W = $clog2(PPW),
  localparam int WSEL_W = ROW_W - LANE_W,
  localparam int ADDR_W = COL_W + WSEL_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 smp_valid,
  output logic                 smp_ready,
  input  logic [COL_W-1:0]     smp_col,
  input  logic [ROW_W-1:0]     smp_row,
  input  logic                 refresh_start,
  input  logic [RND_W-1:0]     decay_prob,
  output logic                 sweep_busy,
  output logic                 mem_rd_en,
  output logic                 mem_wr_en,
  output logic [ADDR_W-1:0]    mem_addr,
  output logic [WORD_BITS-1:0] mem_wdata,
  input  logic [WORD_BITS-1:0] mem_rdata
);
  import persist_pkg::*;

  eng_state_t        state_q, state_d;
  logic [ADDR_W-1:0] hold_addr_q;
  logic [LANE_W-1:0] hold_lane_q;
  logic              smp_take;
  logic              sweep_step;
  logic              swp_active;
  logic [COL_W-1:0]  swp_col;
  logic [WSEL_W-1:0] swp_word;
  logic [WSEL_W-1:0] smp_word;
  logic [LANE_W-1:0] smp_lane;
  logic [PPW*RND_W-1:0] rnd_bytes;

  assign smp_word = smp_row[ROW_W-1:LANE_W];
  assign smp_lane = smp_row[LANE_W-1:0];

  // Samples behind the sweep front may cut in; others wait for the front to pass.
  assign smp_ready  = (state_q == ST_ISSUE) && (!swp_active || (smp_col < swp_col));
  assign smp_take   = smp_valid && smp_ready;
  assign sweep_busy = swp_active;

  persist_sweep_seq #(
    .NUM_COLS(NUM_COLS), .WPC(WPC), .COL_W(COL_W), .WSEL_W(WSEL_W)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .start(refresh_start), .step(sweep_step),
    .active(swp_active), .col(swp_col), .word(swp_word)
  );

  persist_rand #(.LANES(PPW), .RND_W(RND_W)) u_rand (
    .clk(clk), .rst_n(rst_n), .advance(sweep_step), .rnd(rnd_bytes)
  );

  persist_xform #(.LANES(PPW), .RND_W(RND_W), .LANE_W(LANE_W)) u_xform (
    .rd_word(mem_rdata), .sweep_mode(state_q == ST_SWP_WB), .tgt_lane(hold_lane_q),
    .rnd(rnd_bytes), .prob(decay_prob), .wr_word(mem_wdata)
  );

  always_comb begin
    state_d    = state_q;
    mem_rd_en  = 1'b0;
    mem_wr_en  = 1'b0;
    mem_addr   = hold_addr_q;
    sweep_step = 1'b0;
    unique case (state_q)
      ST_ISSUE: begin
        if (smp_take) begin
          mem_rd_en = 1'b1;
          mem_addr  = {smp_col, smp_word};
          state_d   = ST_SMP_WB;
        end else if (swp_active) begin
          mem_rd_en = 1'b1;
          mem_addr  = {swp_col, swp_word};
          state_d   = ST_SWP_WB;
        end
      end
      ST_SMP_WB: begin
        mem_wr_en = 1'b1;
        state_d   = ST_ISSUE;
      end
      ST_SWP_WB: begin
        mem_wr_en  = 1'b1;
        sweep_step = 1'b1;
        state_d    = ST_ISSUE;
      end
      default: state_d = ST_ISSUE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q     <= ST_ISSUE;
      hold_addr_q <= '0;
      hold_lane_q <= '0;
    end else begin
      state_q <= state_d;
      if (mem_rd_en) hold_addr_q <= mem_addr;
      if (smp_take)  hold_lane_q <= smp_lane;
    end
  end

endmodule

// File: rtl/persist_column_checker.sv
module persist_column_checker #(
  parameter int NUM_COLS   = 8,
  parameter int COL_PIXELS = 512,
  parameter int WORD_BITS  = 32,
  localparam int PPW    = WORD_BITS / 2,
  localparam int COL_W  = $clog2(NUM_COLS),
  localparam int ROW_W  = $clog2(COL_PIXELS),
  localparam int LANE_W = $clog2(PPW),
  localparam int WSEL_W = ROW_W - LANE_W,
  localparam int ADDR_W = COL_W + WSEL_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic              smp_valid,
  input logic              smp_ready,
  input logic [COL_W-1:0]  smp_col,
  input logic [ROW_W-1:0]  smp_row,
  input logic              refresh_start,
  input logic              sweep_busy,
  input logic              mem_rd_en,
  input logic              mem_wr_en,
  input logic [ADDR_W-1:0] mem_addr
);

  AST_RW_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd_en && mem_wr_en)); // R10

  AST_READ_THEN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_en |=> mem_wr_en); // R10

  AST_WRITE_SAME_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_en |-> ($past(mem_rd_en) && (mem_addr == $past(mem_addr)))); // R10

  AST_TAKE_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid && smp_ready) |-> (mem_rd_en && (mem_addr == {smp_col, smp_row[ROW_W-1:LANE_W]}))); // R2

  AST_BUSY_FROM_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sweep_busy) |-> $past(refresh_start)); // R7

  AST_BUSY_ENDS_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sweep_busy) |-> $past(mem_wr_en)); // R7

endmodule

bind persist_column_engine persist_column_checker #(
  .NUM_COLS(NUM_COLS), .COL_PIXELS(COL_PIXELS), .WORD_BITS(WORD_BITS)
) u_checker (
  .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_ready(smp_ready),
  .smp_col(smp_col), .smp_row(smp_row), .refresh_start(refresh_start),
  .sweep_busy(sweep_busy), .mem_rd_en(mem_rd_en), .mem_wr_en(mem_wr_en),
  .mem_addr(mem_addr)
);

// File: tb/tb_persist_column_engine.sv
module tb_persist_column_engine;
  localparam int NC        = 8;
  localparam int WPC       = 32;
  localparam int NWORDS    = NC * WPC;
  localparam int SWEEP_CYC = NWORDS * 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        smp_valid = 1'b0;
  logic        smp_ready;
  logic [2:0]  smp_col = '0;
  logic [8:0]  smp_row = '0;
  logic        refresh_start = 1'b0;
  logic [7:0]  decay_prob = '0;
  logic        sweep_busy;
  logic        mem_rd_en, mem_wr_en;
  logic [7:0]  mem_addr;
  logic [31:0] mem_wdata;
  logic [31:0] mem_rdata = '0;

  logic [31:0] mem [0:NWORDS-1];

  int n_checks = 0;
  int n_errs   = 0;
  bit finished = 1'b0;

  int unsigned exp_q[$];
  bit          sb_on = 1'b0;
  string       sb_tag = "R2";

  always #10 clk = ~clk;

  persist_column_engine dut (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_ready(smp_ready),
    .smp_col(smp_col), .smp_row(smp_row), .refresh_start(refresh_start),
    .decay_prob(decay_prob), .sweep_busy(sweep_busy), .mem_rd_en(mem_rd_en),
    .mem_wr_en(mem_wr_en), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata)
  );

  // Column memory model: synchronous read, write on the edge.
  always @(posedge clk) begin
    if (mem_rd_en) mem_rdata <= mem[mem_addr];
    if (mem_wr_en) mem[mem_addr] <= mem_wdata;
  end

  task automatic check(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_errs++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // Scoreboard monitor: write-back addresses must match the expected order.
  always @(negedge clk) begin
    if (sb_on && mem_wr_en) begin
      if (exp_q.size() == 0) begin
        check(1'b0, sb_tag, "unexpected write address", mem_addr, 0);
      end else begin
        int unsigned e;
        e = exp_q.pop_front();
        check(mem_addr == e[7:0], sb_tag, "write address order", mem_addr, e);
      end
    end
  end

  function automatic int pix(input int col, input int row);
    return int'((mem[col*WPC + row/16] >> (2*(row%16))) & 32'd3);
  endfunction

  task automatic fill(input logic [31:0] v);
    for (int i = 0; i < NWORDS; i++) mem[i] = v;
  endtask

  task automatic send_sample(input int col, input int row, output int stalls);
    bit took;
    stalls = 0;
    took = 1'b0;
    @(negedge clk);
    smp_valid = 1'b1;
    smp_col = 3'(col);
    smp_row = 9'(row);
    while (!took) begin
      #1;
      if (smp_ready) begin
        @(posedge clk);
        took = 1'b1;
      end else begin
        stalls++;
        @(negedge clk);
      end
    end
    @(negedge clk);
    smp_valid = 1'b0;
    @(negedge clk);
  endtask

  task automatic pulse_refresh();
    @(negedge clk);
    refresh_start = 1'b1;
    @(negedge clk);
    refresh_start = 1'b0;
  endtask

  task automatic run_refresh(input int retrig_at, output int busy_cyc);
    pulse_refresh();
    busy_cyc = 0;
    while (sweep_busy) begin
      busy_cyc++;
      refresh_start = (busy_cyc == retrig_at);
      @(negedge clk);
    end
    refresh_start = 1'b0;
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      check(1'b0, "WDOG", "watchdog expired", 0, 1);
      summary();
      $finish;
    end
  end

  initial begin
    int st, busy, mism, bad, dark;
    logic [31:0] pre, expw;
    fill(32'h0);

    // R1: reset state
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(sweep_busy == 1'b0, "R1", "sweep_busy after reset", sweep_busy, 0);
    check(smp_ready == 1'b1, "R1", "smp_ready after reset", smp_ready, 1);
    check(mem_rd_en == 1'b0 && mem_wr_en == 1'b0, "R1", "memory idle after reset",
          {mem_rd_en, mem_wr_en}, 0);

    // R2: sample read-modify-write, address and lane mapping
    sb_tag = "R2";
    sb_on  = 1'b1;
    mem[97]  = 32'h5555_5555;
    mem[255] = 32'h0;
    mem[0]   = 32'hFFFF_FFFF;
    mem[176] = 32'hAAAA_AAAA;
    pre = mem[97];  exp_q.push_back(97);  send_sample(3, 17, st);
    check(mem[97] == 32'h5555_555D, "R2", "col3 row17 word", mem[97], 32'h5555_555D);
    exp_q.push_back(255); send_sample(7, 511, st);
    check(mem[255] == 32'hC000_0000, "R2", "col7 row511 word", mem[255], 32'hC000_0000);
    exp_q.push_back(0); send_sample(0, 0, st);
    check(mem[0] == 32'hFFFF_FFFF, "R2", "col0 row0 word", mem[0], 32'hFFFF_FFFF);
    exp_q.push_back(176); send_sample(5, 260, st);
    check(mem[176] == 32'hAAAA_ABAA, "R2", "col5 row260 word", mem[176], 32'hAAAA_ABAA);
    check(st == 0, "R2", "idle sample stalls", st, 0);
    sb_on = 1'b0;
    check(exp_q.size() == 0, "R2", "scoreboard drained", exp_q.size(), 0);

    // R3 R4 R5 R7: deterministic sweep, address order and busy time
    fill(32'hE4E4_E4E4);
    decay_prob = 8'd0;
    sb_tag = "R7";
    for (int a = 0; a < NWORDS; a++) exp_q.push_back(a);
    sb_on = 1'b1;
    run_refresh(-1, busy);
    sb_on = 1'b0;
    check(busy == SWEEP_CYC, "R7", "busy cycles", busy, SWEEP_CYC);
    check(exp_q.size() == 0, "R7", "all words visited", exp_q.size(), 0);
    mism = 0;
    for (int a = 0; a < NWORDS; a++) if (mem[a] != 32'h4444_4444) mism++;
    check(mism == 0, "R3", "11->01 and 01 kept (R4 R5 too)", mism, 0);
    check(mem[9] == 32'h4444_4444, "R4", "00 and 10 become 00", mem[9], 32'h4444_4444);

    // R8: restart strobe during a sweep is ignored
    run_refresh(100, busy);
    check(busy == SWEEP_CYC, "R8", "busy cycles with retrigger", busy, SWEEP_CYC);
    mism = 0;
    for (int a = 0; a < NWORDS; a++) if (mem[a] != 32'h4444_4444) mism++;
    check(mism == 0, "R5", "lit pixels kept at prob 0", mism, 0);

    // R6: random extinction statistics
    fill(32'h5555_5555);
    decay_prob = 8'd128;
    run_refresh(-1, busy);
    dark = 0; bad = 0;
    for (int c = 0; c < NC; c++)
      for (int r = 0; r < 512; r++) begin
        if (pix(c, r) == 0) dark++;
        else if (pix(c, r) != 1) bad++;
      end
    check(dark >= 1024 && dark <= 3072, "R6", "dark count at prob 128", dark, 2048);
    check(bad == 0, "R6", "codes other than 00/01 after decay", bad, 0);
    fill(32'h5555_5555);
    decay_prob = 8'd255;
    run_refresh(-1, busy);
    dark = 0;
    for (int c = 0; c < NC; c++)
      for (int r = 0; r < 512; r++) if (pix(c, r) == 0) dark++;
    check(dark >= 3687, "R6", "dark count at prob 255", dark, 4096);

    // R9: samples during a sweep
    fill(32'h0);
    decay_prob = 8'd0;
    pulse_refresh();
    repeat (266) @(negedge clk);
    send_sample(1, 10, st);
    check(st <= 2, "R9", "behind-front sample stall", st, 0);
    send_sample(6, 3, st);
    check(st >= 100, "R9", "ahead-of-front sample held", st, 100);
    while (sweep_busy) @(negedge clk);
    check(pix(1, 10) == 3, "R9", "behind-front pixel stays fresh", pix(1, 10), 3);
    check(pix(6, 3) == 3, "R9", "held pixel ends fresh", pix(6, 3), 3);
    check(pix(6, 4) == 0, "R9", "neighbour untouched", pix(6, 4), 0);

    // R10: port discipline observed at the ports over a sample
    @(negedge clk);
    smp_valid = 1'b1; smp_col = 3'd2; smp_row = 9'd0;
    @(negedge clk);
    smp_valid = 1'b0;
    check(mem_wr_en == 1'b1 && mem_rd_en == 1'b0 && mem_addr == 8'd64, "R10",
          "write follows read at same address", {mem_rd_en, mem_wr_en, mem_addr}, {2'b01, 8'd64});
    @(negedge clk);

    if (!finished) begin
      finished = 1'b1;
      summary();
      $finish;
    end
  end

endmodule